// File: doc/BRIEF.md
# Single-Wire Bus Slot Timer

This block is the timing engine of a master on a single-wire, open-drain serial bus. It takes one command at a time: a bus reset with presence detection, a single bit touch (write or read), or an eight-bit write or read. It then produces the matching time slots on the line. It never drives the line high. It either pulls the line low or lets the external pull-up take it. The bus level comes back through a two-flop synchronizer. It is sampled at a fixed point inside each slot that reads.

All slot intervals are counted in units of one "tick". A tick lasts `CLKS_PER_US` system clocks times a runtime scale value. The scale is captured when a command is accepted. A scale of zero is treated as one. While a command runs, `busy` is high and new commands are ignored. On the clock edge where `busy` falls, `done` pulses for one cycle and `result` holds the sampled data.

Command codes on `cmd_op`: 0 = bus reset, 1 = touch bit (`cmd_data[0]` gives the bit), 2 = read bit, 3 = write byte (`cmd_data`), 4 = read byte.

Top module: `owm_master`

## Requirements
- R1: A reset (code 0) holds the line low for 480 units, then releases it. It samples the line 70 units after the release and ends 410 units after the sample, so `busy` stays high for 960 units.
- R2: The reset result in `result[0]` is the sampled line level: 0 when a device pulls the line low (presence), 1 when the line stays high. `result[7:1]` is 0.
- R3: A slot that sends a 1 holds the line low for 6 units. The slot lasts 70 units in total.
- R4: A slot that sends a 0 holds the line low for 60 units, then releases it for 10 units. Its result bit is 0.
- R5: A read bit (code 2), or a touch with bit value 1, is a 1-slot that samples the line 15 units after the slot begins. The sampled level is returned in `result[0]`.
- R6: One unit equals `CLKS_PER_US` clocks times `scale`, with `scale` captured at acceptance. A `scale` of 0 acts as 1.
- R7: A byte write (code 3) sends `cmd_data` bit 0 first and bit 7 last, in eight back-to-back slots lasting 560 units in total. `result` returns the eight sampled bits.
- R8: A byte read (code 4) runs eight read slots. The first sampled bit lands in `result[0]` and the last in `result[7]`.
- R9: A command presented while `busy` is high is ignored. The running operation keeps its length, and no further slot follows it.
- R10: `done` is a one-cycle pulse that occurs on the edge where `busy` falls. It is never high while `busy` is high.
- R11: After reset the line is released, and `busy` and `done` are low.
- R12: Command codes 5 to 7 are ignored. The line stays released and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 8 | Bit or byte to send |
| scale | input | SCALE_W | Interval multiplier, 0 acts as 1 |
| bus_in | input | 1 | Raw level of the bus line |
| bus_pull_low | output | 1 | 1 = pull line low, 0 = release |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | Sampled bits of the last operation |

## Verification
The bench measures every low pulse and the whole busy window to the exact cycle. A unit counter that is off by one, or a phase that restarts late between byte slots, shows up as a wrong width or a wrong total. A bus model that answers with a presence pulse or with data bits catches three faults: a sample taken at the wrong instant, a polarity mistake on the presence result, and bits packed from the wrong end. Separate cases cover a scale of 3 and a scale of 0, a command injected mid-slot, and illegal codes. A design that rescaled incorrectly would stretch the slots wrongly. One that accepted the injected command would extend `busy` or add a slot. One that accepted an illegal code would raise `busy` or pull the line low.

// File: rtl/owm_pkg.sv
package owm_pkg;

    typedef enum logic [2:0] {
        OP_RESET = 3'd0,
        OP_TBIT  = 3'd1,
        OP_RBIT  = 3'd2,
        OP_WBYTE = 3'd3,
        OP_RBYTE = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        SK_RESET = 2'd0,
        SK_ONE   = 2'd1,
        SK_ZERO  = 2'd2
    } slot_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_GAP  = 2'd2,
        PH_TAIL = 2'd3
    } phase_e;

    localparam int DUR_W = 9;

    // Units the line is held low at the start of a slot.
    function automatic logic [DUR_W-1:0] low_units(slot_kind_e k);
        case (k)
            SK_RESET: low_units = 9'd480;
            SK_ZERO:  low_units = 9'd60;
            default:  low_units = 9'd6;
        endcase
    endfunction

    // Units from the release up to the sample point (or the slot end for a 0).
    function automatic logic [DUR_W-1:0] gap_units(slot_kind_e k);
        case (k)
            SK_RESET: gap_units = 9'd70;
            SK_ZERO:  gap_units = 9'd10;
            default:  gap_units = 9'd9;
        endcase
    endfunction

    // Units after the sample point; zero means no tail phase.
    function automatic logic [DUR_W-1:0] tail_units(slot_kind_e k);
        case (k)
            SK_RESET: tail_units = 9'd410;
            SK_ZERO:  tail_units = 9'd0;
            default:  tail_units = 9'd55;
        endcase
    endfunction

endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    // Reset to the released (pulled-up) level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/owm_tick.sv
module owm_tick #(
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [LIM_W-1:0] lim_i,
    output logic             tick_o
);
    logic [LIM_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q >= lim_i - 1'b1);
        if (restart_i || tick_o) cnt_d = '0;
        else                     cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && lim_i > 1) |=> !tick_o);
endmodule

// File: rtl/owm_slot.sv
module owm_slot
    import owm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  slot_kind_e kind_i,
    input  logic       tick_i,
    input  logic       lvl_i,
    output logic       pull_o,
    output logic       bit_o,
    output logic       done_o
);
    typedef struct packed {
        phase_e            phase;
        slot_kind_e        kind;
        logic [DUR_W-1:0]  left;
        logic              pull;
        logic              bit_v;
    } slot_st_t;

    slot_st_t st_d, st_q;
    logic     last_unit;

    always_comb begin
        last_unit = tick_i && (st_q.left == '0);
        done_o    = last_unit &&
                    ((st_q.phase == PH_TAIL) ||
                     (st_q.phase == PH_GAP && tail_units(st_q.kind) == '0));

        st_d = st_q;
        if (start_i) begin
            st_d.phase = PH_LOW;
            st_d.kind  = kind_i;
            st_d.left  = low_units(kind_i) - 1'b1;
            st_d.pull  = 1'b1;
            st_d.bit_v = 1'b0;
        end else if (tick_i && st_q.phase != PH_IDLE) begin
            if (st_q.left != '0) begin
                st_d.left = st_q.left - 1'b1;
            end else begin
                case (st_q.phase)
                    PH_LOW: begin
                        st_d.phase = PH_GAP;
                        st_d.left  = gap_units(st_q.kind) - 1'b1;
                        st_d.pull  = 1'b0;
                    end
                    PH_GAP: begin
                        if (st_q.kind != SK_ZERO) st_d.bit_v = lvl_i;
                        if (tail_units(st_q.kind) == '0) begin
                            st_d.phase = PH_IDLE;
                        end else begin
                            st_d.phase = PH_TAIL;
                            st_d.left  = tail_units(st_q.kind) - 1'b1;
                        end
                    end
                    default: st_d.phase = PH_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.kind  <= SK_ONE;
            st_q.left  <= '0;
            st_q.pull  <= 1'b0;
            st_q.bit_v <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pull_o = st_q.pull;
    assign bit_o  = st_q.bit_v;

    // R1
    low_starts_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull_o) |-> $past(start_i));

    // R4
    release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pull_o) |-> $past(tick_i));
endmodule

// File: rtl/owm_master.sv
module owm_master
    import owm_pkg::*;
#(
    parameter int CLKS_PER_US = 100,
    parameter int SCALE_W     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [7:0]         cmd_data,
    input  logic [SCALE_W-1:0] scale,
    input  logic               bus_in,
    output logic               bus_pull_low,
    output logic               busy,
    output logic               done,
    output logic [7:0]         result
);
    localparam int LIM_W = $clog2(CLKS_PER_US + 1) + SCALE_W + 1;

    typedef struct packed {
        logic               busy;
        logic               done;
        op_e                op;
        logic [7:0]         sh;
        logic [7:0]         res;
        logic [2:0]         idx;
        logic [SCALE_W-1:0] scale;
    } ctl_st_t;

    ctl_st_t    st_d, st_q;
    logic       accept, start, is_byte, first_bit, start_bit;
    logic       slot_done, slot_bit, tick, lvl;
    slot_kind_e kind;
    logic [SCALE_W-1:0] eff_scale;
    logic [LIM_W-1:0]   lim;

    owm_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_i(bus_in), .sync_o(lvl)
    );

    always_comb begin
        eff_scale = (st_q.scale == '0) ? SCALE_W'(1) : st_q.scale;
        lim       = LIM_W'(CLKS_PER_US) * LIM_W'(eff_scale);
    end

    owm_tick #(.LIM_W(LIM_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .restart_i(start), .lim_i(lim), .tick_o(tick)
    );

    owm_slot slot_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .kind_i(kind),
        .tick_i(tick), .lvl_i(lvl), .pull_o(bus_pull_low),
        .bit_o(slot_bit), .done_o(slot_done)
    );

    always_comb begin
        accept  = cmd_valid && !st_q.busy && (cmd_op <= 3'd4);
        is_byte = (st_q.op == OP_WBYTE) || (st_q.op == OP_RBYTE);

        case (op_e'(cmd_op))
            OP_TBIT, OP_WBYTE: first_bit = cmd_data[0];
            default:           first_bit = 1'b1;
        endcase

        start     = accept || (slot_done && st_q.busy && is_byte && st_q.idx != 3'd7);
        start_bit = accept ? first_bit : st_q.sh[1];
        if (accept && op_e'(cmd_op) == OP_RESET) kind = SK_RESET;
        else if (start_bit)                      kind = SK_ONE;
        else                                     kind = SK_ZERO;

        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            st_d.busy  = 1'b1;
            st_d.op    = op_e'(cmd_op);
            st_d.sh    = (op_e'(cmd_op) == OP_RBYTE) ? 8'hFF : cmd_data;
            st_d.res   = '0;
            st_d.idx   = '0;
            st_d.scale = scale;
        end else if (slot_done && st_q.busy) begin
            if (is_byte) begin
                st_d.res = {slot_bit, st_q.res[7:1]};
                if (st_q.idx != 3'd7) begin
                    st_d.idx = st_q.idx + 1'b1;
                    st_d.sh  = {1'b0, st_q.sh[7:1]};
                end else begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end
            end else begin
                st_d.res  = {7'b0, slot_bit};
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy  <= 1'b0;
            st_q.done  <= 1'b0;
            st_q.op    <= OP_RESET;
            st_q.sh    <= '0;
            st_q.res   <= '0;
            st_q.idx   <= '0;
            st_q.scale <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = st_q.busy;
    assign done   = st_q.done;
    assign result = st_q.res;

    // R10
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    op_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !slot_done) |=> $stable(st_q.op) && $stable(st_q.scale));
endmodule

// File: tb/owm_master_tb.sv
module owm_master_tb_top;
    localparam int P = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_data = 8'd0;
    logic [3:0] scale = 4'd1;
    logic       bus_in = 1'b1;
    logic       bus_pull_low, busy, done;
    logic [7:0] result;

    int total = 0;
    int bad = 0;

    // bus device model state
    int   dev_mode = 0;     // 0 none, 1 presence, 2 data
    logic [7:0] dev_byte = 8'hFF;
    int   bitptr = 0;
    int   lim_b = P;
    logic prev_pl = 1'b0;
    logic cur_bit = 1'b1;
    logic dev_low = 1'b0;
    int   since_fall = 100000;
    int   since_rel = 100000;

    always #2 clk = ~clk;

    owm_master #(.CLKS_PER_US(P), .SCALE_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .scale(scale), .bus_in(bus_in),
        .bus_pull_low(bus_pull_low), .busy(busy), .done(done), .result(result)
    );

    initial begin
        forever begin
            @(negedge clk);
            if (bus_pull_low && !prev_pl) begin
                since_fall = 0;
                if (dev_mode == 2) begin
                    cur_bit = dev_byte[bitptr % 8];
                    bitptr++;
                end
            end else begin
                since_fall++;
            end
            if (!bus_pull_low && prev_pl) since_rel = 0;
            else                          since_rel++;
            prev_pl = bus_pull_low;
            dev_low = (dev_mode == 1 && !bus_pull_low && since_rel < 200 * lim_b) ||
                      (dev_mode == 2 && !cur_bit && since_fall < 30 * lim_b);
            bus_in  = !(bus_pull_low || dev_low);
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [7:0] d, input logic [3:0] sc,
                          input int inject_at, output int busy_n, output int lows[8],
                          output int nlow, output logic [7:0] res);
        int cur;
        int early;
        cur = 0; early = 0; nlow = 0; busy_n = 0;
        for (int i = 0; i < 8; i++) lows[i] = 0;
        @(negedge clk);
        cmd_op = op; cmd_data = d; scale = sc; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy && busy_n < 100000) begin
            busy_n++;
            if (bus_pull_low) cur++;
            else if (cur > 0) begin
                if (nlow < 8) lows[nlow] = cur;
                nlow++;
                cur = 0;
            end
            if (done) early++;
            if (busy_n == inject_at) begin
                cmd_op = 3'd0; cmd_valid = 1'b1;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        res = result;
        check(early == 0, "R10 done while busy", early, 0);
        check(done == 1'b1, "R10 done at busy fall", int'(done), 1);
        @(negedge clk);
        check(done == 1'b0, "R10 done one cycle", int'(done), 0);
    endtask

    task automatic t_reset_state();
        check(bus_pull_low == 1'b0, "R11 line released", int'(bus_pull_low), 0);
        check(busy == 1'b0, "R11 busy low", int'(busy), 0);
        check(done == 1'b0, "R11 done low", int'(done), 0);
    endtask

    task automatic t_bus_reset(input int present);
        int bn, nl; int lw[8]; logic [7:0] r;
        dev_mode = present ? 1 : 0; lim_b = P;
        run_op(3'd0, 8'h00, 4'd1, 0, bn, lw, nl, r);
        check(lw[0] == 480 * P, "R1 reset low width", lw[0], 480 * P);
        check(bn == 960 * P, "R1 reset busy length", bn, 960 * P);
        check(r == (present ? 8'h00 : 8'h01), "R2 presence result", int'(r), present ? 0 : 1);
        dev_mode = 0;
    endtask

    task automatic t_bit(input logic [2:0] op, input logic v, input logic [3:0] sc,
                         input int mode, input logic devbit, input logic [7:0] exp_r,
                         input string req);
        int bn, nl, u; int lw[8]; logic [7:0] r;
        u = P * ((sc == 0) ? 1 : int'(sc));
        lim_b = u; dev_mode = mode; dev_byte = {8{devbit}}; bitptr = 0;
        run_op(op, {7'b0, v}, sc, 0, bn, lw, nl, r);
        check(nl == 1, {req, " slot count"}, nl, 1);
        check(lw[0] == ((op == 3'd1 && !v) ? 60 : 6) * u, {req, " low width"},
              lw[0], ((op == 3'd1 && !v) ? 60 : 6) * u);
        check(bn == 70 * u, {req, " slot length"}, bn, 70 * u);
        check(r == exp_r, {req, " result"}, int'(r), int'(exp_r));
        dev_mode = 0;
    endtask

    task automatic t_write_byte(input logic [7:0] d);
        int bn, nl; int lw[8]; logic [7:0] r;
        dev_mode = 0; lim_b = P;
        run_op(3'd3, d, 4'd1, 0, bn, lw, nl, r);
        check(nl == 8, "R7 slot count", nl, 8);
        for (int i = 0; i < 8; i++)
            check(lw[i] == (d[i] ? 6 : 60) * P, "R7 bit order width", lw[i], (d[i] ? 6 : 60) * P);
        check(bn == 560 * P, "R7 byte length", bn, 560 * P);
        check(r == d, "R7 byte result", int'(r), int'(d));
    endtask

    task automatic t_read_byte(input logic [7:0] dv);
        int bn, nl; int lw[8]; logic [7:0] r;
        dev_mode = 2; dev_byte = dv; bitptr = 0; lim_b = P;
        run_op(3'd4, 8'h00, 4'd1, 0, bn, lw, nl, r);
        check(nl == 8, "R8 slot count", nl, 8);
        for (int i = 0; i < 8; i++)
            check(lw[i] == 6 * P, "R8 read low width", lw[i], 6 * P);
        check(r == dv, "R8 read byte result", int'(r), int'(dv));
        dev_mode = 0;
    endtask

    task automatic t_busy_ignore();
        int bn, nl, extra; int lw[8]; logic [7:0] r;
        dev_mode = 0; lim_b = P; extra = 0;
        run_op(3'd1, 8'h00, 4'd1, 20, bn, lw, nl, r);
        check(bn == 70 * P, "R9 length unchanged", bn, 70 * P);
        check(nl == 1, "R9 single slot", nl, 1);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (busy || bus_pull_low) extra++;
        end
        check(extra == 0, "R9 no trailing activity", extra, 0);
    endtask

    task automatic t_bad_op();
        int act;
        for (int c = 5; c < 8; c++) begin
            act = 0;
            @(negedge clk);
            cmd_op = 3'(c); cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
            for (int i = 0; i < 10; i++) begin
                if (busy || bus_pull_low) act++;
                @(negedge clk);
            end
            check(act == 0, "R12 illegal code ignored", act, 0);
        end
    endtask

    initial begin
        #600000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset_state();
        t_bus_reset(0);
        t_bus_reset(1);
        t_bit(3'd1, 1'b1, 4'd1, 0, 1'b1, 8'h01, "R3 write one");
        t_bit(3'd1, 1'b0, 4'd1, 0, 1'b1, 8'h00, "R4 write zero");
        t_bit(3'd2, 1'b0, 4'd1, 2, 1'b0, 8'h00, "R5 read low");
        t_bit(3'd2, 1'b0, 4'd1, 2, 1'b1, 8'h01, "R5 read high");
        t_bit(3'd1, 1'b1, 4'd1, 2, 1'b0, 8'h00, "R5 touch one sampled");
        t_bit(3'd1, 1'b0, 4'd3, 0, 1'b1, 8'h00, "R6 scale three");
        t_bit(3'd1, 1'b1, 4'd0, 0, 1'b1, 8'h01, "R6 scale zero");
        t_write_byte(8'hA5);
        t_read_byte(8'h3C);
        t_busy_ignore();
        t_bad_op();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule